// File: doc/BRIEF.md
# Memory Bus Chip-Select Decoder

This block sits between an embedded 8-bit processor core and an external memory bus. For each processor memory cycle it picks one target: the flash device, the SRAM device or a small window of on-chip registers. It drives the matching select and presents a 17-bit memory address. The low eight address bits share pins with data, so the block captures them while the address strobe is high and keeps them for the rest of the cycle.

The processor's own upper-region select steers a cycle to flash. Out of reset that region is the top kilobyte, so the first fetch at FFFF0h goes to flash. Every other cycle goes to SRAM, with two exceptions. The lowest 64 bytes address on-chip registers. An optional alias mode also sends the top 32 KB of the lower space to flash.

The block stretches each access with a ready signal. Two 3-bit wait fields, one for flash and one for SRAM, set how many clocks ready is held back. Register-window accesses never wait.

Top module: `mbus_csel`

## Requirements
- R1: A cycle whose address phase has `ucs_act` high selects flash (`flash_ce_n` low, `sram_ce_n` high, `reg_sel` low) for the whole cycle. This holds at any address, including FFFF0h and the register window.
- R2: A cycle without `ucs_act` selects SRAM (`sram_ce_n` low only) when it is outside the register window and outside an active alias region.
- R3: A cycle without `ucs_act` at a 20-bit address from 0x00000 to 0x0003F raises `reg_sel`, leaves both chip enables high and returns ready with zero wait. Address 0x00040 selects SRAM.
- R4: `ma` equals bits 16:0 of the address built from `a_hi` and the `ad` value sampled on the last clock with `ale` high. `ma` stays unchanged while `ad` carries data.
- R5: With a wait field of N, `rdy` first rises in the (N+1)-th clock of the data strobe, and stays high while `strb` stays high. Flash cycles use the flash field and SRAM cycles use the SRAM field.
- R6: Both wait fields reset to 7. A write with `cfg_we` high and `cfg_sel` = 0 loads the flash field from `cfg_wdata`; `cfg_sel` = 1 loads the SRAM field. A new value applies to cycles that start after the write.
- R7: With `alias_en` high, a cycle without `ucs_act` whose address bits 16:15 are both 1 selects flash and uses the flash wait. With `alias_en` low, the same cycle selects SRAM.
- R8: A cycle starts on the first clock with `ale` low after a clock with `ale` high. It ends on the clock after `strb` falls. Outside a cycle, and from reset, `flash_ce_n` and `sram_ce_n` are high and `reg_sel` and `rdy` are low. At most one target is selected at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address strobe; address is sampled while high |
| ad | input | 8 | Multiplexed low address / data bus |
| a_hi | input | 12 | Address bits 19:8 |
| ucs_act | input | 1 | Processor upper-region select, active high |
| strb | input | 1 | Data-phase strobe of the current cycle |
| alias_en | input | 1 | Enables the flash alias in the lower space |
| cfg_we | input | 1 | Wait-field write enable |
| cfg_sel | input | 1 | 0 selects the flash field, 1 the SRAM field |
| cfg_wdata | input | 3 | New wait count |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| reg_sel | output | 1 | On-chip register window select |
| ma | output | 17 | Memory address bus |
| rdy | output | 1 | Ready back to the processor |

## Verification
The assertions assume a well-formed bus protocol:
- `ale` is high for at least one clock.
- The address and `ucs_act` are stable while `ale` is high.
- `strb` never overlaps `ale`.
- `alias_en` does not change while `ale` falls.
- No wait-field write lands on the clock where a cycle starts.

The stimulus tasks drive whole bus cycles in that fixed order, with configuration writes only between cycles, so every checked cycle stays inside these assumptions. A behavioural model in the bench tracks the cycle state and remaining wait count, and the outputs are compared with it on every clock.

// File: rtl/mbus_csel_pkg.sv
package mbus_csel_pkg;

    // Target of one processor memory cycle
    typedef enum logic [1:0] {
        TGT_SRAM  = 2'd0,
        TGT_FLASH = 2'd1,
        TGT_REGS  = 2'd2
    } tgt_e;

endpackage

// File: rtl/mbus_csel_latch.sv
// Captures the multiplexed address while the strobe is high and flags
// the clock on which a new cycle begins.
module mbus_csel_latch #(
    parameter int ADDR_W = 20,
    parameter int LO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [LO_W-1:0]   ad,
    input  logic [ADDR_W-1:LO_W] a_hi,
    input  logic              ucs_in,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ucs_o,
    output logic              start_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              ucs;
        logic              ale_prev;
    } lat_s;

    lat_s l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (ale) begin
            l_d.addr = {a_hi, ad};
            l_d.ucs  = ucs_in;
        end
        l_d.ale_prev = ale;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign addr_o  = l_q.addr;
    assign ucs_o   = l_q.ucs;
    assign start_o = l_q.ale_prev & ~ale;

endmodule

// File: rtl/mbus_csel_map.sv
// Address map: upper select first, then the register window, then the
// optional flash alias, and SRAM for everything else.
module mbus_csel_map
    import mbus_csel_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int MA_W        = 17,
    parameter int WIN_BYTES   = 64,
    parameter int ALIAS_BYTES = 32768,
    parameter bit HAS_ALIAS   = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ucs,
    input  logic              alias_en,
    output tgt_e              tgt
);

    localparam int WIN_W   = $clog2(WIN_BYTES);
    localparam int ALIAS_W = $clog2(ALIAS_BYTES);

    logic in_win;
    logic in_alias;

    assign in_win = (addr[ADDR_W-1:WIN_W] == '0);

    generate
        if (HAS_ALIAS) begin : g_alias
            assign in_alias = &addr[MA_W-1:ALIAS_W];
        end else begin : g_no_alias
            assign in_alias = 1'b0;
        end
    endgenerate

    always_comb begin
        if (ucs)                        tgt = TGT_FLASH;
        else if (in_win)                tgt = TGT_REGS;
        else if (alias_en && in_alias)  tgt = TGT_FLASH;
        else                            tgt = TGT_SRAM;
    end

endmodule

// File: rtl/mbus_csel_timer.sv
// Holds the two wait fields and counts down the wait of the live cycle.
module mbus_csel_timer
    import mbus_csel_pkg::*;
#(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [WAIT_W-1:0] cfg_wdata,
    input  logic              start,
    input  tgt_e              tgt,
    input  logic              count_en,
    output logic              zero_o
);

    typedef struct packed {
        logic [WAIT_W-1:0] fw;
        logic [WAIT_W-1:0] sw;
        logic [WAIT_W-1:0] cnt;
    } tim_s;

    tim_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            case (tgt)
                TGT_FLASH: t_d.cnt = t_q.fw;
                TGT_SRAM:  t_d.cnt = t_q.sw;
                default:   t_d.cnt = '0;
            endcase
        end else if (count_en && (t_q.cnt != '0)) begin
            t_d.cnt = t_q.cnt - WAIT_W'(1);
        end
        if (cfg_we) begin
            if (cfg_sel) t_d.sw = cfg_wdata;
            else         t_d.fw = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.fw  <= '1;
            t_q.sw  <= '1;
            t_q.cnt <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign zero_o = (t_q.cnt == '0);

endmodule

// File: rtl/mbus_csel.sv
module mbus_csel
    import mbus_csel_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int LO_W        = 8,
    parameter int MA_W        = 17,
    parameter int WAIT_W      = 3,
    parameter int WIN_BYTES   = 64,
    parameter int ALIAS_BYTES = 32768,
    parameter bit HAS_ALIAS   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ale,
    input  logic [LO_W-1:0]      ad,
    input  logic [ADDR_W-1:LO_W] a_hi,
    input  logic                 ucs_act,
    input  logic                 strb,
    input  logic                 alias_en,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [WAIT_W-1:0]    cfg_wdata,
    output logic                 flash_ce_n,
    output logic                 sram_ce_n,
    output logic                 reg_sel,
    output logic [MA_W-1:0]      ma,
    output logic                 rdy
);

    logic [ADDR_W-1:0] addr;
    logic              ucs_l;
    logic              start;
    tgt_e              map_tgt;
    logic              cnt_zero;

    typedef struct packed {
        logic active;
        logic seen;
        tgt_e tgt;
    } cyc_s;

    cyc_s c_d, c_q;

    mbus_csel_latch #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ale     (ale),
        .ad      (ad),
        .a_hi    (a_hi),
        .ucs_in  (ucs_act),
        .addr_o  (addr),
        .ucs_o   (ucs_l),
        .start_o (start)
    );

    mbus_csel_map #(
        .ADDR_W      (ADDR_W),
        .MA_W        (MA_W),
        .WIN_BYTES   (WIN_BYTES),
        .ALIAS_BYTES (ALIAS_BYTES),
        .HAS_ALIAS   (HAS_ALIAS)
    ) u_map (
        .addr     (addr),
        .ucs      (ucs_l),
        .alias_en (alias_en),
        .tgt      (map_tgt)
    );

    mbus_csel_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .start     (start),
        .tgt       (map_tgt),
        .count_en  (c_q.active & strb),
        .zero_o    (cnt_zero)
    );

    // Cycle tracking: open on the address-strobe fall, close after the strobe
    always_comb begin
        c_d = c_q;
        if (start) begin
            c_d.active = 1'b1;
            c_d.seen   = 1'b0;
            c_d.tgt    = map_tgt;
        end else if (c_q.active) begin
            if (strb)        c_d.seen   = 1'b1;
            else if (c_q.seen) c_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign flash_ce_n = ~(c_q.active && (c_q.tgt == TGT_FLASH));
    assign sram_ce_n  = ~(c_q.active && (c_q.tgt == TGT_SRAM));
    assign reg_sel    =   c_q.active && (c_q.tgt == TGT_REGS);
    assign ma         = addr[MA_W-1:0];
    assign rdy        = c_q.active & strb & cnt_zero;

endmodule

// File: rtl/mbus_csel_chk.sv
module mbus_csel_chk #(
    parameter int MA_W = 17
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ale,
    input logic            strb,
    input logic            rdy,
    input logic            flash_ce_n,
    input logic            sram_ce_n,
    input logic            reg_sel,
    input logic [MA_W-1:0] ma
);

    assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~flash_ce_n, ~sram_ce_n, reg_sel}));

    assert_rdy_in_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> (~flash_ce_n | ~sram_ce_n | reg_sel));

    assert_ma_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && !$past(ale)) |-> $stable(ma));

    assert_window_no_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && strb) |-> rdy);

    assert_rdy_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !ale) |=> (rdy || !strb));

endmodule

bind mbus_csel mbus_csel_chk #(.MA_W(MA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ale        (ale),
    .strb       (strb),
    .rdy        (rdy),
    .flash_ce_n (flash_ce_n),
    .sram_ce_n  (sram_ce_n),
    .reg_sel    (reg_sel),
    .ma         (ma)
);

// File: tb/mbus_csel_tb.sv
module mbus_csel_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0;
    logic [7:0]  ad = '0;
    logic [11:0] a_hi = '0;
    logic        ucs_act = 1'b0;
    logic        strb = 1'b0;
    logic        alias_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [2:0]  cfg_wdata = '0;
    logic        flash_ce_n, sram_ce_n, reg_sel, rdy;
    logic [16:0] ma;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit chk_on = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mbus_csel u_dut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .ad(ad), .a_hi(a_hi),
        .ucs_act(ucs_act), .strb(strb), .alias_en(alias_en),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .flash_ce_n(flash_ce_n), .sram_ce_n(sram_ce_n), .reg_sel(reg_sel),
        .ma(ma), .rdy(rdy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int        m_fw, m_sw, m_wait, m_tgt;   // m_tgt: 0 sram, 1 flash, 2 regs
    bit        m_active, m_seen, m_ale_prev, m_ucs;
    bit [19:0] m_addr;
    string     m_tag = "R8";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fw = 7; m_sw = 7; m_wait = 0; m_tgt = 0;
            m_active = 0; m_seen = 0; m_ale_prev = 0; m_ucs = 0;
            m_addr = '0; m_tag = "R8";
        end else begin
            if (m_ale_prev && !ale) begin
                m_active = 1; m_seen = 0;
                if (m_ucs)                                   begin m_tgt = 1; m_tag = "R1"; end
                else if (m_addr < 20'd64)                    begin m_tgt = 2; m_tag = "R3"; end
                else if (alias_en && m_addr[16:15] == 2'b11) begin m_tgt = 1; m_tag = "R7"; end
                else                                         begin m_tgt = 0; m_tag = "R2"; end
                m_wait = (m_tgt == 1) ? m_fw : (m_tgt == 0) ? m_sw : 0;
            end else if (m_active) begin
                if (strb) begin
                    m_seen = 1;
                    if (m_wait > 0) m_wait--;
                end else if (m_seen) begin
                    m_active = 0;
                    m_tag = "R8";
                end
            end
            if (ale) begin
                m_addr = {a_hi, ad};
                m_ucs = ucs_act;
            end
            m_ale_prev = ale;
            if (cfg_we) begin
                if (cfg_sel) m_sw = int'(cfg_wdata);
                else         m_fw = int'(cfg_wdata);
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk(flash_ce_n == !(m_active && m_tgt == 1), m_tag, int'(flash_ce_n), int'(!(m_active && m_tgt == 1)));
            chk(sram_ce_n  == !(m_active && m_tgt == 0), m_tag, int'(sram_ce_n),  int'(!(m_active && m_tgt == 0)));
            chk(reg_sel    ==  (m_active && m_tgt == 2), m_tag, int'(reg_sel),    int'(m_active && m_tgt == 2));
            chk(ma == m_addr[16:0], "R4", int'(ma), int'(m_addr[16:0]));
            chk(rdy == (m_active && strb && m_wait == 0), "R5", int'(rdy), int'(m_active && strb && m_wait == 0));
        end
    end

    // ---------------- stimulus ----------------
    task automatic cfg_write(input bit sel, input int val);
        @(posedge clk); #1;
        cfg_we = 1; cfg_sel = sel; cfg_wdata = 3'(val);
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic bus_cycle(input bit [19:0] adr, input bit ucs, input bit als,
                             input int exp_lat, input string tag);
        int lat;
        @(posedge clk); #1;
        ale = 1; ad = adr[7:0]; a_hi = adr[19:8]; ucs_act = ucs; alias_en = als;
        @(posedge clk); #1;
        ale = 0; ad = ~adr[7:0];                 // data phase reuses the pins
        @(posedge clk); #1;
        strb = 1;
        lat = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (rdy) break;
            lat++;
        end
        chk(lat == exp_lat, tag, lat, exp_lat);
        chk(ma == adr[16:0], "R4", int'(ma), int'(adr[16:0]));
        @(posedge clk); #1;
        strb = 0;
        @(posedge clk); #1;
        @(negedge clk);
        chk({flash_ce_n, sram_ce_n, reg_sel, rdy} == 4'b1100, "R8",
            int'({flash_ce_n, sram_ce_n, reg_sel, rdy}), 'hc);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog R8 act=0 exp=1");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk({flash_ce_n, sram_ce_n, reg_sel, rdy} == 4'b1100, "R8",
            int'({flash_ce_n, sram_ce_n, reg_sel, rdy}), 'hc);
        chk_on = 1;

        // reset fetch from the top of the space, default wait of 7 (R6)
        bus_cycle(20'hFFFF0, 1, 0, 7, "R6");
        bus_cycle(20'h04000, 0, 0, 7, "R6");

        cfg_write(0, 2);
        cfg_write(1, 3);
        bus_cycle(20'hF8123, 1, 0, 2, "R5");
        bus_cycle(20'h01234, 0, 0, 3, "R2");

        // register window and its edge (R3)
        bus_cycle(20'h00000, 0, 0, 0, "R3");
        bus_cycle(20'h0003F, 0, 1, 0, "R3");
        bus_cycle(20'h00040, 0, 0, 3, "R3");
        // upper select outranks the window (R1)
        bus_cycle(20'h00010, 1, 0, 2, "R1");

        // alias mode (R7)
        bus_cycle(20'h1C000, 0, 0, 3, "R7");
        bus_cycle(20'h1C000, 0, 1, 2, "R7");
        bus_cycle(20'h17FFF, 0, 1, 3, "R7");
        bus_cycle(20'h1FFFF, 0, 1, 2, "R7");

        // extreme wait values (R5, R6)
        cfg_write(0, 0);
        cfg_write(1, 0);
        bus_cycle(20'hFC000, 1, 0, 0, "R5");
        bus_cycle(20'h0ABCD, 0, 0, 0, "R5");
        cfg_write(1, 7);
        bus_cycle(20'h0ABCD, 0, 0, 7, "R6");
        bus_cycle(20'hFC001, 1, 0, 0, "R6");

        repeat (3) @(posedge clk);
        report();
        $finish;
    end

endmodule